// File: doc/BRIEF.md
# Beam Test Trigger Logic Unit

This block decides when a beam particle has crossed the telescope. It then tells every readout system at once to record the event. Four scintillator discriminator lines arrive asynchronously. Each is synchronized, and its rising edges are collected over a short programmable window. A trigger candidate exists only when all four channels have fired inside that window. When the region-of-interest gate is switched on, a synchronized hit-OR level from the region-of-interest input must also be high.

A candidate becomes a trigger only when the unit is idle. After a trigger it stays closed for a programmable dead-time count. It also stays closed while any readout system holds its busy line. The trigger is driven as a fixed-width pulse on several identical outputs. For bench work without beam, an emulation mode replaces the beam path with a periodic internal tick.

Per-channel hit counters and a 32-bit trigger counter support efficiency checks. The synchronized scintillator levels are brought out for observation. All configuration arrives on plain ports. With a 40 MHz clock, dead-time loads of 4000, 16000, 40000 and 120000 cycles give 100 µs, 400 µs, 1 ms and 3 ms; the last is the intended default setting.

Top module: `beam_trig_unit`

## Requirements
- R1: A beam trigger is issued only when all four scintillator channels show a rising edge; any pattern missing a channel produces no trigger.
- R2: Edges count as coincident when each later edge arrives no more than `cfg_win`-1 cycles after the earliest (with `cfg_win`=4, a skew of 3 cycles triggers and a skew of 4 does not).
- R3: With `cfg_roi_en`=1, a coincidence triggers only while `roi_in` is high; with `cfg_roi_en`=0, `roi_in` has no effect.
- R4: All `NUM_TRIG` bits of `trig_out` carry the same pulse; bits 2 and 3 serve the strip and pad timing detectors.
- R5: While any bit of `busy_in` is high (after synchronization), no trigger is issued and the candidate is discarded.
- R6: Each trigger pulse is exactly `PULSE_CYC` clock cycles wide.
- R7: After a trigger, further candidates are rejected until `cfg_dead` cycles have elapsed after the issuing cycle and every busy line is low.
- R8: With `cfg_emul_en`=1, triggers come from an internal tick every `cfg_emul_period` cycles, and scintillator coincidences are ignored.
- R9: `chan_count` holds one `CHCNT_W`-bit counter per scintillator channel (channel k in bits k*CHCNT_W upward). Each counter counts that channel's rising edges in every mode.
- R10: `trig_count` increases by one for each issued trigger. A one-cycle `cnt_clear` resets it and all channel counters to zero.
- R11: `scint_mon` shows each scintillator input level delayed by two clock edges.
- R12: After reset, `trig_out`, `trig_count` and `chan_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scint_in | input | NUM_SCINT | Asynchronous scintillator discriminator lines |
| roi_in | input | 1 | Asynchronous region-of-interest hit-OR level |
| busy_in | input | NUM_BUSY | Asynchronous busy lines, one per readout system |
| cfg_roi_en | input | 1 | Require region-of-interest gate |
| cfg_emul_en | input | 1 | Select periodic emulated triggers |
| cfg_win | input | WIN_W | Coincidence window in cycles (1 or more) |
| cfg_dead | input | DEAD_W | Dead-time length in cycles |
| cfg_emul_period | input | PER_W | Emulation period in cycles (2 or more) |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| trig_out | output | NUM_TRIG | Trigger pulse to each readout system |
| scint_mon | output | NUM_SCINT | Synchronized scintillator levels |
| trig_count | output | 32 | Issued trigger count |
| chan_count | output | NUM_SCINT*CHCNT_W | Per-channel rising-edge counts |

## Verification
Full four-channel pulses are contrasted with three-channel subsets, which separates the AND from any partial match. Skews of three and four cycles locate the edge of the window exactly. Coincidences are repeated with the region gate on and its level low and high, and again with a busy line held, so each veto is seen to act alone. Back-to-back coincidences inside and beyond the dead time, a busy line that outlasts the dead time, and beam pulses injected during emulation show which path owns the trigger in each case.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam int TRIG_CNT_W = 32;
  typedef logic [TRIG_CNT_W-1:0] trig_cnt_t;
endpackage

// File: rtl/btu_sync.sv
module btu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/btu_coinc.sv
module btu_coinc #(
  parameter int NCH   = 4,
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NCH-1:0]   lvl,
  input  logic [WIN_W-1:0] win,
  output logic [NCH-1:0]   rise,
  output logic             hit
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] armed;

  assign rise = lvl & ~prev_q;
  assign hit  = &armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [WIN_W-1:0] tmr_q;
    logic [WIN_W-1:0] tmr_d;

    assign armed[g] = en & (rise[g] | (tmr_q != '0));

    always_comb begin
      tmr_d = tmr_q;
      if (!en || hit)              tmr_d = '0;
      else if (rise[g])            tmr_d = (win == '0) ? '0 : win - 1'b1;
      else if (tmr_q != '0)        tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_q <= '0;
      else        tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/btu_holdoff.sv
module btu_holdoff #(
  parameter int DEAD_W    = 18,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand,
  input  logic              busy_any,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              fire,
  output logic              trig,
  output logic              dead_on
);
  localparam int PW_W = $clog2(PULSE_CYC + 1);
  localparam logic [PW_W-1:0] PW_LOAD = PW_W'(PULSE_CYC);

  logic [PW_W-1:0]   pw_q, pw_d;
  logic [DEAD_W-1:0] dead_q, dead_d;

  assign trig    = (pw_q != '0);
  assign dead_on = (dead_q != '0);
  assign fire    = cand & ~trig & ~dead_on & ~busy_any;

  always_comb begin
    pw_d   = pw_q;
    dead_d = dead_q;
    if (fire) begin
      pw_d   = PW_LOAD;
      dead_d = dead_len;
    end else begin
      if (trig)    pw_d   = pw_q - 1'b1;
      if (dead_on) dead_d = dead_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q   <= '0;
      dead_q <= '0;
    end else begin
      pw_q   <= pw_d;
      dead_q <= dead_d;
    end
  end
endmodule

// File: rtl/beam_trig_unit.sv
module beam_trig_unit
  import btu_pkg::*;
#(
  parameter int NUM_SCINT = 4,
  parameter int NUM_BUSY  = 3,
  parameter int NUM_TRIG  = 4,
  parameter int WIN_W     = 4,
  parameter int DEAD_W    = 18,
  parameter int PER_W     = 16,
  parameter int PULSE_CYC = 4,
  parameter int CHCNT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SCINT-1:0]         scint_in,
  input  logic                         roi_in,
  input  logic [NUM_BUSY-1:0]          busy_in,
  input  logic                         cfg_roi_en,
  input  logic                         cfg_emul_en,
  input  logic [WIN_W-1:0]             cfg_win,
  input  logic [DEAD_W-1:0]            cfg_dead,
  input  logic [PER_W-1:0]             cfg_emul_period,
  input  logic                         cnt_clear,
  output logic [NUM_TRIG-1:0]          trig_out,
  output logic [NUM_SCINT-1:0]         scint_mon,
  output logic [TRIG_CNT_W-1:0]        trig_count,
  output logic [NUM_SCINT*CHCNT_W-1:0] chan_count
);
  logic [1:0]           rst_pipe;
  logic                 rst_i;
  logic [NUM_SCINT-1:0] scint_lvl;
  logic [NUM_SCINT-1:0] scint_rise;
  logic [0:0]           roi_lvl;
  logic [NUM_BUSY-1:0]  busy_lvl;
  logic                 busy_any;
  logic                 coin_hit;
  logic                 roi_ok;
  logic                 emul_tick;
  logic                 cand;
  logic                 fire;
  logic                 trig;
  logic                 dead_on;
  logic [PER_W-1:0]     emul_q, emul_d;
  trig_cnt_t            tcnt_q, tcnt_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  btu_sync #(.W(NUM_SCINT)) u_sync_sc (.clk(clk), .rst_n(rst_i), .d(scint_in), .q(scint_lvl));
  btu_sync #(.W(1))         u_sync_roi (.clk(clk), .rst_n(rst_i), .d(roi_in), .q(roi_lvl));
  btu_sync #(.W(NUM_BUSY))  u_sync_busy (.clk(clk), .rst_n(rst_i), .d(busy_in), .q(busy_lvl));

  assign busy_any  = |busy_lvl;
  assign scint_mon = scint_lvl;
  assign roi_ok    = ~cfg_roi_en | roi_lvl[0];

  btu_coinc #(.NCH(NUM_SCINT), .WIN_W(WIN_W)) u_coinc (
    .clk(clk), .rst_n(rst_i), .en(~cfg_emul_en), .lvl(scint_lvl),
    .win(cfg_win), .rise(scint_rise), .hit(coin_hit)
  );

  // periodic emulation tick
  assign emul_tick = cfg_emul_en & (emul_q == cfg_emul_period - 1'b1);
  always_comb begin
    emul_d = emul_q;
    if (!cfg_emul_en)                          emul_d = '0;
    else if (emul_q >= cfg_emul_period - 1'b1) emul_d = '0;
    else                                       emul_d = emul_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) emul_q <= '0;
    else        emul_q <= emul_d;
  end

  assign cand = cfg_emul_en ? emul_tick : (coin_hit & roi_ok);

  btu_holdoff #(.DEAD_W(DEAD_W), .PULSE_CYC(PULSE_CYC)) u_holdoff (
    .clk(clk), .rst_n(rst_i), .cand(cand), .busy_any(busy_any),
    .dead_len(cfg_dead), .fire(fire), .trig(trig), .dead_on(dead_on)
  );

  assign trig_out = {NUM_TRIG{trig}};

  // trigger counter
  always_comb begin
    tcnt_d = tcnt_q;
    if (cnt_clear) tcnt_d = '0;
    else if (fire) tcnt_d = tcnt_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end
  assign trig_count = tcnt_q;

  // per-channel hit counters
  for (genvar g = 0; g < NUM_SCINT; g++) begin : g_cnt
    logic [CHCNT_W-1:0] hc_q, hc_d;
    always_comb begin
      hc_d = hc_q;
      if (cnt_clear)          hc_d = '0;
      else if (scint_rise[g]) hc_d = hc_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) hc_q <= '0;
      else        hc_q <= hc_d;
    end
    assign chan_count[g*CHCNT_W +: CHCNT_W] = hc_q;
  end
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int NUM_TRIG  = 4,
  parameter int PULSE_CYC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TRIG-1:0] trig_out,
  input logic [31:0]         trig_count,
  input logic                cnt_clear,
  input logic                busy_any,
  input logic                dead_on
);
  AST_FANOUT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out == {NUM_TRIG{trig_out[0]}}); // R4

  AST_NO_TRIG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out[0]) |-> !$past(busy_any)); // R5

  AST_NO_TRIG_IN_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out[0]) |-> !$past(dead_on)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig_out[0]) && !$past(cnt_clear)) |-> trig_count == $past(trig_count) + 32'd1); // R10

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(trig_out[0]) && !$past(cnt_clear)) |-> $stable(trig_count)); // R10

  if (PULSE_CYC > 1) begin : g_pw
    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_out[0]) |=> trig_out[0]); // R6
  end
endmodule

bind beam_trig_unit btu_checker #(.NUM_TRIG(NUM_TRIG), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .trig_count(trig_count),
  .cnt_clear(cnt_clear), .busy_any(busy_any), .dead_on(dead_on)
);

// File: tb/tb_beam_trig_unit.sv
module tb_beam_trig_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int CW = 16;
  // [15:12] channel mask, [11:8] skew of channel 3, [7] roi gate on,
  // [6] roi level, [5] busy held, [4] trigger expected
  localparam logic [15:0] VEC [8] = '{
    16'hF010, 16'h7000, 16'hE000, 16'hF310,
    16'hF400, 16'hF080, 16'hF0D0, 16'hF020
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  scint_in;
  logic        roi_in;
  logic [2:0]  busy_in;
  logic        cfg_roi_en, cfg_emul_en, cnt_clear;
  logic [3:0]  cfg_win;
  logic [17:0] cfg_dead;
  logic [15:0] cfg_emul_period;
  logic [3:0]  trig_out;
  logic [3:0]  scint_mon;
  logic [31:0] trig_count;
  logic [63:0] chan_count;

  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, hi = 0, fanbad = 0, last = 0, gap = 0;
  logic prev_t = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_trig_unit dut (
    .clk(clk), .rst_n(rst_n), .scint_in(scint_in), .roi_in(roi_in), .busy_in(busy_in),
    .cfg_roi_en(cfg_roi_en), .cfg_emul_en(cfg_emul_en), .cfg_win(cfg_win),
    .cfg_dead(cfg_dead), .cfg_emul_period(cfg_emul_period), .cnt_clear(cnt_clear),
    .trig_out(trig_out), .scint_mon(scint_mon), .trig_count(trig_count),
    .chan_count(chan_count)
  );

  always @(negedge clk) begin
    cyc++;
    if (trig_out[0] && !prev_t) begin
      rises++;
      gap  = cyc - last;
      last = cyc;
    end
    if (trig_out[0]) hi++;
    if (trig_out != {4{trig_out[0]}}) fanbad++;
    prev_t = trig_out[0];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire_pat(input logic [3:0] m, input int skew);
    @(negedge clk);
    scint_in[2:0] = m[2:0];
    if (skew == 0) scint_in[3] = m[3];
    for (int c = 1; c <= skew + 2; c++) begin
      @(negedge clk);
      if (c == 2) scint_in[2:0] = 3'b000;
      if (skew != 0 && c == skew) scint_in[3] = m[3];
      if (c == skew + 2) scint_in[3] = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] t0;
    logic [63:0] cc0;
    int r0, h0;
    rst_n = 1'b0; scint_in = '0; roi_in = 1'b0; busy_in = '0;
    cfg_roi_en = 1'b0; cfg_emul_en = 1'b0; cnt_clear = 1'b0;
    cfg_win = 4'd4; cfg_dead = 18'd30; cfg_emul_period = 16'd25;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R12 reset state
    chk(trig_out == 4'b0, "R12", trig_out, 0);
    chk(trig_count == 32'd0, "R12", trig_count, 0);
    chk(chan_count == 64'd0, "R12", chan_count, 0);

    // table: R1 R2 R3 R5 R9 R6
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      string tag;
      v = VEC[i];
      tag = v[7] ? "R3" : (v[5] ? "R5" : ((v[11:8] != 0) ? "R2" : "R1"));
      cfg_roi_en = v[7]; roi_in = v[6]; busy_in[1] = v[5];
      wait_cyc(4);
      t0 = trig_count; r0 = rises; h0 = hi; cc0 = chan_count;
      fire_pat(v[15:12], int'(v[11:8]));
      wait_cyc(50);
      busy_in[1] = 1'b0; roi_in = 1'b0; cfg_roi_en = 1'b0;
      chk(trig_count - t0 == 32'(v[4]), tag, trig_count - t0, v[4]);
      chk(rises - r0 == int'(v[4]), tag, rises - r0, v[4]);
      chk(hi - h0 == int'(v[4]) * PW, "R6", hi - h0, int'(v[4]) * PW);
      for (int ch = 0; ch < 4; ch++)
        chk(chan_count[ch*CW +: CW] - cc0[ch*CW +: CW] == 16'(v[12+ch]), "R9",
            chan_count[ch*CW +: CW] - cc0[ch*CW +: CW], v[12+ch]);
      wait_cyc(40);
    end

    // R7 second coincidence inside the dead time is dropped
    t0 = trig_count;
    fire_pat(4'hF, 0);
    wait_cyc(10);
    fire_pat(4'hF, 0);
    wait_cyc(50);
    chk(trig_count == t0 + 1, "R7", trig_count, t0 + 1);
    fire_pat(4'hF, 0);
    wait_cyc(50);
    chk(trig_count == t0 + 2, "R7", trig_count, t0 + 2);

    // R7 busy outlasting the dead time keeps the unit closed
    t0 = trig_count;
    fire_pat(4'hF, 0);
    wait_cyc(3);
    busy_in[2] = 1'b1;
    wait_cyc(60);
    fire_pat(4'hF, 0);
    wait_cyc(20);
    chk(trig_count == t0 + 1, "R7", trig_count, t0 + 1);
    busy_in[2] = 1'b0;
    wait_cyc(10);
    fire_pat(4'hF, 0);
    wait_cyc(40);
    chk(trig_count == t0 + 2, "R7", trig_count, t0 + 2);

    // R4 fan-out identical throughout
    chk(fanbad == 0, "R4", fanbad, 0);

    // R11 monitor latency
    cc0 = chan_count;
    @(negedge clk); scint_in = 4'b0010;
    @(negedge clk);
    chk(scint_mon == 4'b0000, "R11", scint_mon, 0);
    @(negedge clk);
    chk(scint_mon == 4'b0010, "R11", scint_mon, 2);
    scint_in = 4'b0000;
    wait_cyc(10);
    chk(chan_count[CW +: CW] == cc0[CW +: CW] + 1, "R9", chan_count[CW +: CW], cc0[CW +: CW] + 1);

    // R8 emulation: periodic, beam ignored
    cfg_dead = 18'd10;
    cfg_emul_en = 1'b1;
    r0 = rises;
    for (int k = 0; k < 100 && rises == r0; k++) @(negedge clk);
    r0 = rises;
    for (int k = 0; k < 8; k++) begin
      fire_pat(4'hF, 0);
      wait_cyc(27);
    end
    chk(rises - r0 == 9, "R8", rises - r0, 9);
    chk(gap == 25, "R8", gap, 25);
    cfg_emul_en = 1'b0;
    wait_cyc(30);

    // R10 counter clear
    chk(trig_count != 32'd0, "R10", trig_count, 1);
    @(negedge clk); cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0;
    chk(trig_count == 32'd0, "R10", trig_count, 0);
    chk(chan_count == 64'd0, "R10", chan_count, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule